// File: doc/BRIEF.md
# Segment Translation Unit with Cached Descriptors

This block is the segmentation stage in front of an address pipeline. It keeps six segment slots. Each slot holds a 16-bit selector that software can see and a descriptor copy that it cannot see. A load request names a slot and a selector. The unit then decodes the selector and picks the global or the local descriptor table. It reads the two-word descriptor entry through a simple memory port and stores it in the slot. A read must wait for the previous one to return.

A memory access names a slot, a 32-bit offset, a read/write flag and a user/supervisor flag. The unit works only from the cached descriptor and never touches the tables here. It adds the cached base to the offset to give a linear address, and it checks the offset and the access type against the descriptor. One cycle later it reports the linear address and a fault code.

An access to the slot that is being refilled is held back until the refill ends. Accesses to any other slot keep flowing while the refill is in progress. A descriptor with base zero passes the offset through unchanged, which switches segmentation off for that slot.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every slot holds an absent descriptor, and `out_valid`, `mem_req`, `ld_busy` and `acc_stall` are low.
- R2: A load of selector S reads two words. The first is at T + 8*S[15:3], where T is `ltab_base` when S[2]=1 and `gtab_base` when S[2]=0. The second is at that address plus 4, and it is requested only after the first word has returned.
- R3: The first word of a descriptor is the 32-bit base. In the second word, bit 31 is present, bit 30 is writable, bit 29 is user-accessible and bits 23:0 are the highest legal offset. The slot is updated when the second word arrives.
- R4: An access accepted on a clock edge yields `out_valid`=1 on the next cycle, with `out_lin` = base + offset (modulo 2^32) whenever `out_fault`=0.
- R5: An offset greater than the cached limit gives fault code 2. An offset equal to the limit is legal.
- R6: A write to a slot whose writable bit is clear gives fault code 3.
- R7: A user-level access to a slot whose user-accessible bit is clear gives fault code 4. An access counts as user-level when `acc_user`=1 or when the slot's selector bits 1:0 are nonzero.
- R8: An access through a descriptor whose present bit is clear gives fault code 1.
- R9: When several faults apply, the lowest number wins in this order: absent (1), limit (2), write-protect (3), privilege (4). Fault code 0 means no fault.
- R10: Accesses never raise `mem_req`; table reads happen only during a load.
- R11: While a slot is loading, an access to that slot raises `acc_stall` and is not accepted until the refill ends. An access to any other slot is accepted in the same cycles.
- R12: A load request that arrives while `ld_busy`=1 is ignored and leaves its slot unchanged.
- R13: A slot with base zero and no fault returns `out_lin` equal to the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Request to load a selector into a slot |
| ld_seg | input | 3 | Slot number for the load |
| ld_sel | input | 16 | Selector to load |
| ld_busy | output | 1 | A descriptor refill is in progress |
| gtab_base | input | 32 | Base address of the global descriptor table |
| ltab_base | input | 32 | Base address of the local descriptor table |
| mem_req | output | 1 | Descriptor word read request, held until served |
| mem_addr | output | 32 | Descriptor word address |
| mem_rdata | input | 32 | Returned descriptor word |
| mem_rvalid | input | 1 | One-cycle pulse that `mem_rdata` is valid |
| acc_valid | input | 1 | Memory access request |
| acc_seg | input | 3 | Slot used by the access |
| acc_off | input | 32 | Offset within the segment |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | 1 = user-level access |
| acc_stall | output | 1 | Access is held because its slot is loading |
| out_valid | output | 1 | Result of the access accepted one cycle earlier |
| out_lin | output | 32 | Linear address |
| out_fault | output | 3 | Fault code (0 none, 1 absent, 2 limit, 3 write, 4 privilege) |

## Verification
A refill and an access can land in the same cycle. The bench provokes this in three ways, and it judges each by the result that comes out one cycle after the access is accepted:
- It starts a load and, in the very next cycle, presents an access to the same slot. `acc_stall` must stay high and `out_valid` low until the refill ends. The access must then return the new descriptor's base plus the offset.
- It repeats the case with the access aimed at a different slot. This access must come back on the next cycle while `ld_busy` is still high.
- It issues a second load during a refill. The target slot must still report an absent descriptor afterwards.

// File: rtl/seg_xlate_pkg.sv
// Package: shared widths, descriptor record and fault codes for the
// segment translation unit. Assumes 32-bit addresses and 16-bit selectors.
package seg_xlate_pkg;
    localparam int ADDR_W   = 32;
    localparam int SEL_W    = 16;
    localparam int LIM_W    = 24;
    localparam int SEL_TBL  = 2;            // selector bit: 1 = local table
    localparam int SEL_RPL_W = 2;           // selector bits 1:0: privilege request
    localparam int SEL_IDX_LO = 3;          // selector index starts here
    localparam int ENTRY_SH = 3;            // entries are 8 bytes
    localparam int W1_PRES  = 31;
    localparam int W1_WR    = 30;
    localparam int W1_USER  = 29;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              present;
        logic              writable;
        logic              user_ok;
        logic [LIM_W-1:0]  limit;
    } seg_desc_t;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_LIMIT  = 3'd2,
        FLT_WRPROT = 3'd3,
        FLT_PRIV   = 3'd4
    } seg_fault_e;
endpackage

// File: rtl/seg_fill_ctrl.sv
// Descriptor refill sequencer. Takes one load at a time, decodes the
// selector into a table address and reads the two descriptor words.
// It then hands the finished record to the cache.
// Assumes the memory answers each held request with a one-cycle
// mem_rvalid pulse, and that a request never returns data unasked.
module seg_fill_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [ADDR_W-1:0] ltab_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              busy,
    output logic [SEG_W-1:0]  fill_seg,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output seg_desc_t         wr_desc
);
    typedef enum logic [1:0] {F_IDLE, F_W0, F_W1} fill_st_e;

    fill_st_e          st_q;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] entry_off;

    // Decode the selector: choose the table and scale the index to bytes.
    always_comb begin
        tbl_base  = ld_sel[SEL_TBL] ? ltab_base : gtab_base;
        entry_off = ADDR_W'({ld_sel[SEL_W-1:SEL_IDX_LO], ENTRY_SH'(0)});
    end

    // Step through the idle, first-word and second-word states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= F_IDLE;
            sel_q    <= '0;
            addr_q   <= '0;
            base_q   <= '0;
            fill_seg <= '0;
        end else begin
            case (st_q)
                F_IDLE: if (ld_valid) begin
                    st_q     <= F_W0;
                    sel_q    <= ld_sel;
                    fill_seg <= ld_seg;
                    addr_q   <= tbl_base + entry_off;
                end
                F_W0: if (mem_rvalid) begin
                    st_q   <= F_W1;
                    base_q <= mem_rdata;
                    addr_q <= addr_q + ADDR_W'(4);
                end
                F_W1: if (mem_rvalid) st_q <= F_IDLE;
                default: st_q <= F_IDLE;
            endcase
        end
    end

    // Drive the memory port and assemble the record from both words.
    always_comb begin
        busy             = (st_q != F_IDLE);
        mem_req          = busy;
        mem_addr         = addr_q;
        wr_en            = (st_q == F_W1) && mem_rvalid;
        wr_sel           = sel_q;
        wr_desc.base     = base_q;
        wr_desc.present  = mem_rdata[W1_PRES];
        wr_desc.writable = mem_rdata[W1_WR];
        wr_desc.user_ok  = mem_rdata[W1_USER];
        wr_desc.limit    = mem_rdata[LIM_W-1:0];
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R2
    AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_W0 && mem_rvalid) |=> (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R2
endmodule

// File: rtl/seg_desc_cache.sv
// Store for each slot's selector and cached descriptor, with one write
// port from the refill sequencer and one combinational read port for accesses.
// Assumes a slot number beyond NUM_SEGS-1 reads back as an absent record.
module seg_desc_cache
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    parameter int SEG_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [SEL_W-1:0]  wr_sel,
    input  seg_desc_t         wr_desc,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic [SEL_W-1:0]  rd_sel,
    output seg_desc_t         rd_desc
);
    seg_desc_t [NUM_SEGS-1:0]             desc_q;
    logic      [NUM_SEGS-1:0][SEL_W-1:0]  sel_q;
    logic      [NUM_SEGS-1:0]             hit;

    // Per-slot write decode.
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_seg == SEG_W'(g));
    end

    // Write the finished record into the selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            sel_q  <= '0;
        end else begin
            for (int i = 0; i < NUM_SEGS; i++) begin
                if (hit[i]) begin
                    desc_q[i] <= wr_desc;
                    sel_q[i]  <= wr_sel;
                end
            end
        end
    end

    // Read the slot named by the access.
    always_comb begin
        rd_desc = '0;
        rd_sel  = '0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (rd_seg == SEG_W'(i)) begin
                rd_desc = desc_q[i];
                rd_sel  = sel_q[i];
            end
        end
    end

    AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(desc_q) && $stable(sel_q))); // R12
endmodule

// File: rtl/seg_access_check.sv
// Combinational limit and protection check and base adder for one access.
// Assumes the descriptor and selector come from the cache in the same cycle.
module seg_access_check
    import seg_xlate_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] off,
    input  logic              is_write,
    input  logic              is_user,
    output logic [ADDR_W-1:0] lin,
    output seg_fault_e        fault
);
    logic eff_user;
    logic over_limit;

    // Form the linear address and pick the fault by fixed priority.
    always_comb begin
        lin        = desc.base + off;
        eff_user   = is_user || (sel[SEL_RPL_W-1:0] != '0);
        over_limit = off > ADDR_W'(desc.limit);
        if (!desc.present)                 fault = FLT_ABSENT;
        else if (over_limit)               fault = FLT_LIMIT;
        else if (is_write && !desc.writable) fault = FLT_WRPROT;
        else if (eff_user && !desc.user_ok) fault = FLT_PRIV;
        else                               fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_xlate_unit.sv
// Top of the segment translation unit. Ties the refill sequencer, the
// descriptor cache and the access checker together. It holds back an
// access to a slot that is loading, and registers the result of each accepted access.
// Assumes that ld_seg and acc_seg name slots below NUM_SEGS.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter  int NUM_SEGS = 6,
    localparam int SEG_W    = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    output logic              ld_busy,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [ADDR_W-1:0] ltab_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    input  logic              acc_valid,
    input  logic [SEG_W-1:0]  acc_seg,
    input  logic [ADDR_W-1:0] acc_off,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              acc_stall,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_lin,
    output logic [2:0]        out_fault
);
    logic              wr_en;
    logic [SEL_W-1:0]  wr_sel;
    seg_desc_t         wr_desc;
    logic [SEG_W-1:0]  fill_seg;
    logic [SEL_W-1:0]  rd_sel;
    seg_desc_t         rd_desc;
    logic [ADDR_W-1:0] lin_c;
    seg_fault_e        fault_c;

    seg_fill_ctrl #(.SEG_W(SEG_W)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
        .gtab_base(gtab_base), .ltab_base(ltab_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .busy(ld_busy), .fill_seg(fill_seg),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_desc(wr_desc)
    );

    seg_desc_cache #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_seg(fill_seg), .wr_sel(wr_sel), .wr_desc(wr_desc),
        .rd_seg(acc_seg), .rd_sel(rd_sel), .rd_desc(rd_desc)
    );

    seg_access_check u_check (
        .desc(rd_desc), .sel(rd_sel), .off(acc_off),
        .is_write(acc_write), .is_user(acc_user),
        .lin(lin_c), .fault(fault_c)
    );

    // Hold back an access whose slot is the one being refilled.
    assign acc_stall = acc_valid && ld_busy && (acc_seg == fill_seg);

    // Register the result of each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_lin   <= '0;
            out_fault <= '0;
        end else begin
            out_valid <= acc_valid && !acc_stall;
            if (acc_valid && !acc_stall) begin
                out_lin   <= lin_c;
                out_fault <= fault_c;
            end
        end
    end

    AST_STALL_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> ld_busy); // R11
    AST_OUT_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(acc_valid && !acc_stall)); // R4
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_busy |-> !mem_req); // R10
    AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fault <= 3'd4)); // R9
endmodule

// File: tb/seg_xlate_unit_bench.sv
// Directed bench for the segment translation unit: a small descriptor
// memory model, one task per scenario, and results sampled on falling edges.
module seg_xlate_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic        ld_busy;
    logic [31:0] gtab_base = 32'h0000_0000;
    logic [31:0] ltab_base = 32'h0000_0200;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        mem_rvalid;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_seg = '0;
    logic [31:0] acc_off = '0;
    logic        acc_write = 1'b0;
    logic        acc_user = 1'b0;
    logic        acc_stall;
    logic        out_valid;
    logic [31:0] out_lin;
    logic [2:0]  out_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] bmem [0:255];

    always #5 clk = ~clk;

    seg_xlate_unit u_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_busy(ld_busy),
        .gtab_base(gtab_base), .ltab_base(ltab_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
        .acc_write(acc_write), .acc_user(acc_user), .acc_stall(acc_stall),
        .out_valid(out_valid), .out_lin(out_lin), .out_fault(out_fault)
    );

    // Descriptor memory: answers a held request after one cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            mem_rdata  <= bmem[mem_addr[9:2]];
        end
    end

    function automatic logic [31:0] w1(bit pres, bit wr, bit usr, logic [23:0] lim);
        return {pres, wr, usr, 5'b0, lim};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] seg, input logic [15:0] sel,
                           input logic [31:0] exp_addr, input string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = seg; ld_sel = sel;
        @(negedge clk);
        ld_valid = 1'b0;
        chk({req, " first word address"}, mem_addr, exp_addr);
        while (mem_addr == exp_addr && ld_busy) @(negedge clk);
        chk({req, " second word address"}, mem_addr, exp_addr + 32'd4);
        while (ld_busy) @(negedge clk);
    endtask

    task automatic do_acc(input logic [2:0] seg, input logic [31:0] off, input bit wr,
                          input bit usr, input logic [31:0] exp_lin,
                          input logic [2:0] exp_flt, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_seg = seg; acc_off = off; acc_write = wr; acc_user = usr;
        @(negedge clk);
        acc_valid = 1'b0;
        chk({req, " out_valid"}, 32'(out_valid), 32'd1);
        chk({req, " fault"}, 32'(out_fault), 32'(exp_flt));
        if (exp_flt == 3'd0) chk({req, " linear"}, out_lin, exp_lin);
        chk("R10 no table read on access", 32'(mem_req), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 ld_busy", 32'(ld_busy), 32'd0);
        chk("R1 acc_stall", 32'(acc_stall), 32'd0);
        do_acc(3'd0, 32'h0, 1'b0, 1'b0, 32'h0, 3'd1, "R1 absent after reset");
    endtask

    task automatic t_loads;
        do_load(3'd0, 16'h0008, 32'h0000_0008, "R2 global idx1");
        do_load(3'd1, 16'h0010, 32'h0000_0010, "R2 global idx2");
        do_load(3'd2, 16'h001C, 32'h0000_0218, "R2 local idx3");
        do_load(3'd3, 16'h001D, 32'h0000_0218, "R2 local idx3 rpl1");
        do_load(3'd4, 16'h0020, 32'h0000_0020, "R2 global idx4");
    endtask

    task automatic t_translate;
        do_acc(3'd0, 32'h123, 1'b0, 1'b1, 32'h1000_0123, 3'd0, "R3 R4 base plus offset");
        do_acc(3'd0, 32'hFFF, 1'b1, 1'b0, 32'h1000_0FFF, 3'd0, "R5 offset at limit");
        do_acc(3'd0, 32'h1000, 1'b0, 1'b0, 32'h0, 3'd2, "R5 offset past limit");
        do_acc(3'd1, 32'h00AB_CDEF, 1'b0, 1'b0, 32'h00AB_CDEF, 3'd0, "R13 zero base");
        do_acc(3'd1, 32'h40, 1'b1, 1'b0, 32'h0, 3'd3, "R6 write read-only");
        do_acc(3'd1, 32'h40, 1'b0, 1'b1, 32'h0, 3'd4, "R7 user on supervisor");
        do_acc(3'd1, 32'h40, 1'b1, 1'b1, 32'h0, 3'd3, "R9 write beats privilege");
        do_acc(3'd2, 32'h40, 1'b0, 1'b0, 32'h0000_4040, 3'd0, "R4 local base");
        do_acc(3'd2, 32'h100, 1'b1, 1'b1, 32'h0, 3'd2, "R9 limit beats privilege");
        do_acc(3'd3, 32'h40, 1'b0, 1'b0, 32'h0, 3'd4, "R7 selector rpl user");
        do_acc(3'd4, 32'h0, 1'b0, 1'b0, 32'h0, 3'd1, "R8 not present");
        do_acc(3'd4, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0, 3'd1, "R9 absent beats all");
    endtask

    task automatic t_stall_same_slot;
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd2; ld_sel = 16'h002F;
        @(negedge clk);
        ld_valid = 1'b0;
        acc_valid = 1'b1; acc_seg = 3'd2; acc_off = 32'h8; acc_write = 1'b0; acc_user = 1'b0;
        #1;
        chk("R11 stall raised", 32'(acc_stall), 32'd1);
        while (acc_stall) begin
            @(negedge clk);
            chk("R11 no result while stalled", 32'(out_valid), 32'd0);
        end
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R11 result after refill", 32'(out_valid), 32'd1);
        chk("R11 new base used", out_lin, 32'h8000_0008);
        chk("R11 new descriptor fault", 32'(out_fault), 32'd0);
    endtask

    task automatic t_other_slot_during_fill;
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd3; ld_sel = 16'h0008;
        @(negedge clk);
        ld_valid = 1'b0;
        acc_valid = 1'b1; acc_seg = 3'd0; acc_off = 32'h10; acc_write = 1'b0; acc_user = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R11 other slot served", 32'(out_valid), 32'd1);
        chk("R11 other slot linear", out_lin, 32'h1000_0010);
        chk("R11 fill still running", 32'(ld_busy), 32'd1);
        while (ld_busy) @(negedge clk);
        do_acc(3'd3, 32'h5, 1'b1, 1'b1, 32'h1000_0005, 3'd0, "R3 slot reloaded");
    endtask

    task automatic t_load_while_busy;
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd4; ld_sel = 16'h0008;
        @(negedge clk);
        ld_seg = 3'd5; ld_sel = 16'h0008;
        @(negedge clk);
        ld_valid = 1'b0;
        while (ld_busy) @(negedge clk);
        do_acc(3'd5, 32'h5, 1'b0, 1'b0, 32'h0, 3'd1, "R12 busy load ignored");
        do_acc(3'd4, 32'h5, 1'b0, 1'b0, 32'h1000_0005, 3'd0, "R12 first load kept");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = '0;
        bmem[2]   = 32'h1000_0000; bmem[3]   = w1(1, 1, 1, 24'h000FFF);
        bmem[4]   = 32'h0000_0000; bmem[5]   = w1(1, 0, 0, 24'hFFFFFF);
        bmem[8]   = 32'h0000_1234; bmem[9]   = w1(0, 1, 1, 24'h00FFFF);
        bmem[134] = 32'h0000_4000; bmem[135] = w1(1, 1, 0, 24'h0000FF);
        bmem[138] = 32'h8000_0000; bmem[139] = w1(1, 1, 1, 24'h000010);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_translate();
        t_stall_same_slot();
        t_other_slot_during_fill();
        t_load_while_busy();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule